// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM Core

This block is a single-port synchronous memory whose read and write cycles are both pipelined. Because the pipeline is the same length for both, they can be issued back to back in any mix, with no dead cycle between a write and a following read. A word is 18 bits wide and is split into two 9-bit lanes. Each lane holds 8 data bits and one parity bit, and each lane has its own active-low write strobe. The array depth is a parameter.

A command (select, write enable, lane strobes, address) is sampled on every rising clock edge where the clock enable is low. Two enabled edges later, a read returns its data and a write takes its data from the input bus. An active-low clock enable stalls the whole pipeline. Three chip enables combine into a single select. An asynchronous active-low output enable gates the data drive. The bidirectional bus is modelled as separate input data, output data and output-drive signals, and the core turns the drive off whenever no read data is due, whatever the output enable says.

Top module: `sram_zbt_core`

## Requirements
- R1: An operation is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0 on an enabled edge. Any other combination is a deselect: no write takes place and no read data is driven, whatever `wr_n` is.
- R2: A read sampled on enabled edge E returns the addressed word on `q` after enabled edge E+2. If `oe_n` is low, `q_drv` is 1 for that cycle.
- R3: A write (`wr_n`=0 while selected) sampled on enabled edge E stores `d` as it stands at enabled edge E+2.
- R4: `lane_n[0]`=0 enables bits [8:0] and `lane_n[1]`=0 enables bits [17:9]. A lane whose strobe is 1 keeps its previous contents. The strobes are ignored on reads.
- R5: The parity bits (bit 8 for lane 0, bit 17 for lane 1) are written or kept under their lane strobe, in the same way as the data bits.
- R6: `oe_n` acts on `q_drv` asynchronously, with no clock edge between. When `oe_n`=1, `q_drv`=0.
- R7: `q_drv` is 0 in any cycle without read data due. This covers the data phase of a write, deselected cycles, and the first cycle after leaving deselect, and it holds even when `oe_n`=0.
- R8: When `cen_n`=1 on an edge, no command is sampled, no write occurs and `q`/`q_drv` hold their values. The stalled cycle is simply stretched.
- R9: Reads and writes can alternate on consecutive enabled edges with no idle cycles, and every access completes correctly.
- R10: A read issued while an earlier write to the same address is still in the pipeline returns the newly written lanes merged with the lanes that were kept.
- R11: After synchronous reset (`rst`=1 on a rising edge) the pipeline is empty and `q_drv`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the pipeline |
| cen_n | input | 1 | Clock enable, active low; high stalls the pipeline |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1 | input | 1 | Chip select 1, active high |
| cs2_n | input | 1 | Chip select 2, active low |
| wr_n | input | 1 | Write enable, active low |
| lane_n | input | 2 | Per-lane write strobes, active low |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d | input | 18 | Write data, sampled two enabled edges after the command |
| q | output | 18 | Read data |
| q_drv | output | 1 | Output drive enable for the data bus |

## Verification
On every clock cycle, the assertions check three things: that a non-selecting edge leaves no operation in the pipeline, that a sampled read moves one stage per enabled edge, and that a stalled edge leaves the output register and the drive state unchanged. They also check that drive is off in any cycle following an edge at which no read sat in the last stage. Two further properties can only be shown by the bench's reference model across scenarios: the data values themselves (lane merging, parity handling, forwarding of in-flight writes), and the asynchronous reaction of `q_drv` to `oe_n` between clock edges.

// File: rtl/sram_zbt_pkg.sv
package sram_zbt_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lanes_t;

    typedef struct packed {
        logic   vld;
        logic   wr;
        lanes_t lane_we;
    } op_t;

    function automatic word_t lane_merge(input word_t old_w, input word_t new_w,
                                         input lanes_t take);
        word_t r;
        for (int i = 0; i < LANES; i++) begin
            r[i*LANE_W +: LANE_W] = take[i] ? new_w[i*LANE_W +: LANE_W]
                                            : old_w[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/sram_cmd_pipe.sv
module sram_cmd_pipe
    import sram_zbt_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cen_n,
    input  logic          cs0_n,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic          wr_n,
    input  lanes_t        lane_n,
    input  logic [AW-1:0] addr,
    output logic          s1_rd,
    output logic [AW-1:0] s1_addr,
    output op_t           s2_op,
    output logic [AW-1:0] s2_addr
);

    op_t           s1_q, s2_q;
    logic [AW-1:0] a1_q, a2_q;
    logic          sel;

    assign sel = !cs0_n && cs1 && !cs2_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else if (!cen_n) begin
            s1_q.vld     <= sel;
            s1_q.wr      <= sel && !wr_n;
            s1_q.lane_we <= ~lane_n;
            s2_q         <= s1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!cen_n) begin
            a1_q <= addr;
            a2_q <= a1_q;
        end
    end

    assign s1_rd   = s1_q.vld && !s1_q.wr;
    assign s1_addr = a1_q;
    assign s2_op   = s2_q;
    assign s2_addr = a2_q;

    // R1: a non-selecting enabled edge leaves nothing in the first stage
    p_deselect_r1: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !(!cs0_n && cs1 && !cs2_n)) |=> !s1_q.vld);

    // R2: a read moves to the second stage on the next enabled edge
    p_read_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && s1_rd) |=> (s2_q.vld && !s2_q.wr));

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sram_zbt_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          wr_en,
    input  lanes_t        wr_lane,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_data,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_data
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lane[g]) begin
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/sram_read_path.sv
module sram_read_path
    import sram_zbt_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          s1_rd,
    input  logic [AW-1:0] s1_addr,
    input  op_t           s2_op,
    input  logic [AW-1:0] s2_addr,
    input  word_t         din,
    input  word_t         arr_data,
    output word_t         q,
    output logic          q_rd
);

    word_t rdbuf_q, q_q;
    logic  q_rd_q;
    logic  fwd;
    word_t rd_next;

    // write committing on this edge to the address being read: forward it
    assign fwd     = s2_op.vld && s2_op.wr && (s2_addr == s1_addr);
    assign rd_next = fwd ? lane_merge(arr_data, din, s2_op.lane_we) : arr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdbuf_q <= '0;
            q_q     <= '0;
            q_rd_q  <= 1'b0;
        end else if (adv) begin
            if (s1_rd) begin
                rdbuf_q <= rd_next;
            end
            q_q    <= rdbuf_q;
            q_rd_q <= s2_op.vld && !s2_op.wr;
        end
    end

    assign q    = q_q;
    assign q_rd = q_rd_q;

endmodule

// File: rtl/sram_zbt_core.sv
module sram_zbt_core
    import sram_zbt_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cen_n,
    input  logic          cs0_n,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic          wr_n,
    input  logic [1:0]    lane_n,
    input  logic [AW-1:0] addr,
    input  logic          oe_n,
    input  logic [17:0]   d,
    output logic [17:0]   q,
    output logic          q_drv
);

    logic          s1_rd;
    logic [AW-1:0] s1_addr, s2_addr;
    op_t           s2_op;
    word_t         arr_data;
    logic          wr_en;
    logic          q_rd;

    sram_cmd_pipe #(.AW(AW)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .cen_n  (cen_n),
        .cs0_n  (cs0_n),
        .cs1    (cs1),
        .cs2_n  (cs2_n),
        .wr_n   (wr_n),
        .lane_n (lane_n),
        .addr   (addr),
        .s1_rd  (s1_rd),
        .s1_addr(s1_addr),
        .s2_op  (s2_op),
        .s2_addr(s2_addr)
    );

    assign wr_en = !cen_n && s2_op.vld && s2_op.wr;

    sram_lane_array #(.AW(AW)) u_array (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_lane(s2_op.lane_we),
        .wr_addr(s2_addr),
        .wr_data(d),
        .rd_addr(s1_addr),
        .rd_data(arr_data)
    );

    sram_read_path #(.AW(AW)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .adv     (!cen_n),
        .s1_rd   (s1_rd),
        .s1_addr (s1_addr),
        .s2_op   (s2_op),
        .s2_addr (s2_addr),
        .din     (d),
        .arr_data(arr_data),
        .q       (q),
        .q_rd    (q_rd)
    );

    assign q_drv = !oe_n && q_rd;

    // R8: a stalled edge leaves the output stage untouched
    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> ($stable(q) && $stable(q_rd)));

    // R7: no read in the last stage at an enabled edge -> no drive after it
    p_no_drive_r7: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !(s2_op.vld && !s2_op.wr)) |=> !q_drv);

endmodule

// File: tb/tb_sram_zbt_core.sv
module tb_sram_zbt_core;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cen_n = 1'b1;
    logic          cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [1:0]    lane_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic          oe_n = 1'b0;
    logic [17:0]   d = '0;
    logic [17:0]   q;
    logic          q_drv;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R11";

    sram_zbt_core #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .cen_n(cen_n), .cs0_n(cs0_n), .cs1(cs1),
        .cs2_n(cs2_n), .wr_n(wr_n), .lane_n(lane_n), .addr(addr),
        .oe_n(oe_n), .d(d), .q(q), .q_drv(q_drv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [17:0] mm [DEPTH];
    bit          m_vld [2];
    bit          m_wr  [2];
    logic [1:0]  m_ln  [2];
    int          m_adr [2];
    bit          m_out_rd = 1'b0;
    logic [17:0] m_out   = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_vld[0] = 1'b0; m_vld[1] = 1'b0; m_out_rd = 1'b0;
        end else if (!cen_n) begin
            if (m_vld[1] && m_wr[1]) begin
                for (int l = 0; l < 2; l++)
                    if (!m_ln[1][l]) mm[m_adr[1]][l*9 +: 9] = d[l*9 +: 9];
            end
            m_out_rd = m_vld[1] && !m_wr[1];
            if (m_out_rd) m_out = mm[m_adr[1]];
            m_vld[1] = m_vld[0]; m_wr[1] = m_wr[0];
            m_ln[1]  = m_ln[0];  m_adr[1] = m_adr[0];
            m_vld[0] = ({cs0_n, cs1, cs2_n} == 3'b010);
            m_wr[0]  = m_vld[0] && !wr_n;
            m_ln[0]  = lane_n;
            m_adr[0] = int'(addr);
        end
    end

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, {17'd0, q_drv}, {17'd0, m_out_rd && !oe_n});
            if (m_out_rd) check(cur_req, q, m_out);
        end
    end

    // ---------------- stimulus ----------------
    // sel: 0 = selected, 1..3 = one of the three selects inactive
    task automatic issue(input bit en, input int sel, input bit wr,
                         input logic [1:0] ln, input int a);
        @(negedge clk); #1;
        cen_n  = !en;
        cs0_n  = (sel == 1);
        cs1    = (sel != 2);
        cs2_n  = (sel == 3);
        wr_n   = !wr;
        lane_n = ln;
        addr   = AW'(a);
        d      = 18'($urandom);
    endtask

    task automatic nop(); issue(1'b1, 1, 1'b0, 2'b11, 0); endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        cur_req = "R11";
        #1 check("R11", {17'd0, q_drv}, 18'd0);

        cur_req = "R3";
        for (int i = 0; i < DEPTH; i++) issue(1'b1, 0, 1'b1, 2'b00, i);
        cur_req = "R2";
        for (int i = 0; i < DEPTH; i++) issue(1'b1, 0, 1'b0, 2'b00, i);

        cur_req = "R9";
        for (int i = 0; i < 24; i++) issue(1'b1, 0, i[0], 2'b00, (i * 7) % DEPTH);

        cur_req = "R4";
        issue(1'b1, 0, 1'b1, 2'b10, 3);
        issue(1'b1, 0, 1'b1, 2'b01, 4);
        issue(1'b1, 0, 1'b1, 2'b11, 5);
        repeat (2) nop();
        issue(1'b1, 0, 1'b0, 2'b01, 3);
        issue(1'b1, 0, 1'b0, 2'b10, 4);
        issue(1'b1, 0, 1'b0, 2'b00, 5);
        repeat (3) nop();

        cur_req = "R5";
        for (int i = 0; i < 8; i++) begin
            issue(1'b1, 0, 1'b1, 2'(i), 10 + i);
            issue(1'b1, 0, 1'b0, 2'b00, 10 + i);
        end
        repeat (3) nop();

        cur_req = "R10";
        issue(1'b1, 0, 1'b1, 2'b10, 20);
        issue(1'b1, 0, 1'b0, 2'b00, 20);
        issue(1'b1, 0, 1'b1, 2'b01, 21);
        nop();
        issue(1'b1, 0, 1'b0, 2'b00, 21);
        issue(1'b1, 0, 1'b1, 2'b00, 22);
        issue(1'b1, 0, 1'b1, 2'b01, 22);
        issue(1'b1, 0, 1'b0, 2'b00, 22);
        repeat (3) nop();

        cur_req = "R1";
        for (int s = 1; s <= 3; s++) begin
            issue(1'b1, s, 1'b1, 2'b00, 30);
            issue(1'b1, s, 1'b0, 2'b00, 30);
        end
        repeat (2) nop();
        issue(1'b1, 0, 1'b0, 2'b00, 30);
        repeat (3) nop();

        cur_req = "R7";
        nop(); nop();
        issue(1'b1, 0, 1'b0, 2'b00, 31);
        issue(1'b1, 0, 1'b1, 2'b00, 32);
        issue(1'b1, 0, 1'b0, 2'b00, 32);
        repeat (3) nop();

        cur_req = "R8";
        issue(1'b1, 0, 1'b1, 2'b00, 40);
        issue(1'b0, 0, 1'b1, 2'b00, 41);
        issue(1'b1, 0, 1'b0, 2'b00, 40);
        issue(1'b0, 0, 1'b0, 2'b11, 40);
        issue(1'b0, 1, 1'b0, 2'b11, 40);
        issue(1'b1, 0, 1'b0, 2'b00, 42);
        issue(1'b0, 0, 1'b1, 2'b00, 42);
        issue(1'b0, 0, 1'b1, 2'b00, 42);
        issue(1'b1, 0, 1'b0, 2'b00, 40);
        repeat (4) nop();

        cur_req = "R6";
        issue(1'b1, 0, 1'b0, 2'b00, 40);
        nop(); nop();
        @(posedge clk); #2;
        oe_n = 1'b1; #1;
        check("R6", {17'd0, q_drv}, 18'd0);
        oe_n = 1'b0; #1;
        check("R6", {17'd0, q_drv}, 18'd1);
        issue(1'b1, 0, 1'b0, 2'b00, 41);
        nop();
        oe_n = 1'b1;
        repeat (3) nop();
        oe_n = 1'b0;
        repeat (2) nop();

        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule